// File: doc/BRIEF.md
# I2C-over-AUX Bus Speed Selector

This block sets the bit rate of a downstream DDC/I2C master whose transfers are bridged from a display auxiliary channel. It exposes a fixed capability bitmap and a speed-control register. A write to the control register gives a mask of the speeds the source will allow. The block keeps the slowest speed that is both allowed by the mask and supported, so that long monitor cables still work.

The chosen speed drives a clock-enable generator. The generator gives a one-cycle tick at four times the selected SCL rate, derived from a fixed reference clock. The I2C master uses the tick to time its quarter-bit phases. A new divider value is taken only while the master is idle, so a transfer in progress never changes rate partway through. While a transfer is running, every request that arrives from the channel side is flagged so that the bridge answers it with a defer reply.

Top module: `ddc_rate_sel`

## Requirements
- R1: During reset the speed is 10 kbit/s (code 0x04) when `strap_slow` is 1, and 50 kbit/s (code 0x80) when it is 0.
- R2: `cap_map` reads 0x8F. Each bit stands for one speed: bit0 1 kbit/s, bit1 3 kbit/s, bit2 10 kbit/s, bit3 100 kbit/s, bit7 50 kbit/s. Bits 4 (400 kbit/s), 5 (1 Mbit/s) and 6 (reserved) read 0.
- R3: A write ANDs `ctl_wr_data` with the capability map and selects the slowest speed left. Writing 0xFF selects 0x01, and writing 0x0C selects 0x04.
- R4: A write whose AND with the capability map is zero leaves `speed_code` unchanged. Writing 0x30 or 0x40 is an example.
- R5: Slowest-first order is bit0, bit1, bit2, bit7, bit3. Writing 0x88 selects 0x80, and writing 0x08 selects 0x08.
- R6: `speed_code` is always one-hot. It changes only on a write, in the cycle after the write.
- R7: `div_tc` equals floor(REF_HZ / (4 × rate)) − 1 for the speed in use. It reloads on each clock where `xfer_busy` is 0 and holds on each clock where `xfer_busy` is 1.
- R8: `qtr_tick` is a one-cycle pulse that repeats every `div_tc` + 1 cycles.
- R9: `defer_reply` is 1 in the cycle after `aux_req` is seen while `xfer_busy` is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_slow | input | 1 | Reset-default speed select (1: 10 kbit/s, 0: 50 kbit/s) |
| ctl_wr_en | input | 1 | Write strobe for the speed-control register |
| ctl_wr_data | input | 8 | Speed mask being written |
| xfer_busy | input | 1 | Downstream I2C transfer in progress |
| aux_req | input | 1 | A channel request has arrived at the bridge |
| cap_map | output | 8 | Capability bitmap (read-only value) |
| speed_code | output | 8 | One-hot code of the speed in use (control register read value) |
| div_tc | output | TCW | Divider terminal count in use |
| qtr_tick | output | 1 | Clock enable at four times the SCL rate |
| defer_reply | output | 1 | Answer the current request with a defer |

## Verification
If the speed register holds a wrong value, `speed_code` shows it in the cycle after the write. The divider picks the error up on the next idle clock, and the tick spacing is wrong from then on. If the reload gate is wrong, `div_tc` moves while `xfer_busy` is high, and this shows within one cycle. If the tick counter is off by one, the tick interval is wrong within a single period. Running the reference model on every clock catches each of these errors at the first cycle where the outputs diverge.

// File: rtl/ddc_rate_pkg.sv
package ddc_rate_pkg;

   localparam int SPD_W = 8;
   typedef logic [SPD_W-1:0] spd_vec_t;

   localparam spd_vec_t SPD_10K = 8'h04;
   localparam spd_vec_t SPD_50K = 8'h80;

   // Bit rate in bit/s encoded by each position of the speed vector.
   function automatic int unsigned bit_rate_hz(input int b);
      case (b)
         0:       return 32'd1000;
         1:       return 32'd3000;
         2:       return 32'd10000;
         3:       return 32'd100000;
         4:       return 32'd400000;
         5:       return 32'd1000000;
         7:       return 32'd50000;
         default: return 32'd0;
      endcase
   endfunction

   // Bit position holding the r-th slowest speed. Bit7 (50k) sits between bit2 and bit3.
   function automatic logic [2:0] slow_rank_bit(input int r);
      case (r)
         0:       return 3'd0;
         1:       return 3'd1;
         2:       return 3'd2;
         3:       return 3'd7;
         4:       return 3'd3;
         5:       return 3'd4;
         6:       return 3'd5;
         default: return 3'd6;
      endcase
   endfunction

   // One-hot of the slowest speed present in m (zero if m carries no rate bit).
   function automatic spd_vec_t pick_slowest(input spd_vec_t m);
      spd_vec_t res;
      logic     found;
      res   = '0;
      found = 1'b0;
      for (int r = 0; r < 7; r++) begin
         if (!found && m[slow_rank_bit(r)]) begin
            res[slow_rank_bit(r)] = 1'b1;
            found = 1'b1;
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/ddc_rate_reg.sv
module ddc_rate_reg
   import ddc_rate_pkg::*;
#(
   parameter spd_vec_t CAP = 8'h8F
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     strap_slow,
   input  logic     wr_en,
   input  spd_vec_t wr_data,
   output spd_vec_t speed_q
);

   spd_vec_t hit;
   spd_vec_t pick;

   always_comb begin
      hit  = wr_data & CAP;
      pick = pick_slowest(hit);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         speed_q <= strap_slow ? SPD_10K : SPD_50K;
      end else if (wr_en && (|hit)) begin
         speed_q <= pick;
      end
   end

endmodule

// File: rtl/ddc_rate_div.sv
module ddc_rate_div
   import ddc_rate_pkg::*;
#(
   parameter int unsigned REF_HZ = 27_000_000,
   parameter spd_vec_t    CAP    = 8'h8F,
   parameter int          TCW    = 13
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           strap_slow,
   input  logic           busy,
   input  spd_vec_t       speed,
   output logic [TCW-1:0] tc_q,
   output logic           tick_q
);

   localparam logic [TCW-1:0] TC_RST_HI = TCW'(REF_HZ / (4 * bit_rate_hz(2)) - 1);
   localparam logic [TCW-1:0] TC_RST_LO = TCW'(REF_HZ / (4 * bit_rate_hz(7)) - 1);

   logic [TCW-1:0] lane [SPD_W];
   logic [TCW-1:0] tc_sel;
   logic [TCW-1:0] cnt_q;

   for (genvar b = 0; b < SPD_W; b++) begin : g_lane
      if (CAP[b]) begin : g_sup
         localparam int unsigned TCV = REF_HZ / (4 * bit_rate_hz(b)) - 1;
         assign lane[b] = speed[b] ? TCW'(TCV) : '0;
      end else begin : g_unsup
         assign lane[b] = '0;
      end
   end

   always_comb begin
      tc_sel = '0;
      for (int b = 0; b < SPD_W; b++) begin
         tc_sel = tc_sel | lane[b];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tc_q   <= strap_slow ? TC_RST_HI : TC_RST_LO;
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         if (!busy) begin
            tc_q <= tc_sel;
         end
         if (cnt_q >= tc_q) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ddc_defer_gen.sv
module ddc_defer_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic busy,
   output logic defer_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         defer_q <= 1'b0;
      end else begin
         defer_q <= req & busy;
      end
   end

endmodule

// File: rtl/ddc_rate_sel.sv
module ddc_rate_sel
   import ddc_rate_pkg::*;
#(
   parameter int unsigned REF_HZ = 27_000_000,
   parameter logic [7:0]  CAP    = 8'h8F,
   parameter int          TCW    = $clog2(REF_HZ / 4000 + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           strap_slow,
   input  logic           ctl_wr_en,
   input  logic [7:0]     ctl_wr_data,
   input  logic           xfer_busy,
   input  logic           aux_req,
   output logic [7:0]     cap_map,
   output logic [7:0]     speed_code,
   output logic [TCW-1:0] div_tc,
   output logic           qtr_tick,
   output logic           defer_reply
);

   localparam int unsigned MAX_TC = REF_HZ / 4000;

   if (CAP[4] || CAP[5] || CAP[6]) begin : g_bad_cap
      $error("capability map claims an unsupported or reserved speed");
   end
   if (!CAP[2] || !CAP[7]) begin : g_bad_dflt
      $error("reset-default speeds must be in the capability map");
   end
   if (REF_HZ / 400000 < 2) begin : g_bad_ref
      $error("reference clock too slow for the fastest supported speed");
   end
   if (MAX_TC >= (1 << TCW)) begin : g_bad_tcw
      $error("TCW too narrow for the slowest speed");
   end

   spd_vec_t speed_q;

   assign cap_map    = CAP;
   assign speed_code = speed_q;

   ddc_rate_reg #(.CAP(CAP)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_slow (strap_slow),
      .wr_en      (ctl_wr_en),
      .wr_data    (ctl_wr_data),
      .speed_q    (speed_q)
   );

   ddc_rate_div #(.REF_HZ(REF_HZ), .CAP(CAP), .TCW(TCW)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_slow (strap_slow),
      .busy       (xfer_busy),
      .speed      (speed_q),
      .tc_q       (div_tc),
      .tick_q     (qtr_tick)
   );

   ddc_defer_gen u_defer (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (aux_req),
      .busy    (xfer_busy),
      .defer_q (defer_reply)
   );

endmodule

// File: rtl/ddc_rate_sel_chk.sv
module ddc_rate_sel_chk #(
   parameter logic [7:0] CAP = 8'h8F,
   parameter int         TCW = 13
) (
   input logic           clk,
   input logic           rst_n,
   input logic           strap_slow,
   input logic           ctl_wr_en,
   input logic [7:0]     ctl_wr_data,
   input logic           xfer_busy,
   input logic           aux_req,
   input logic [7:0]     speed_code,
   input logic [TCW-1:0] div_tc,
   input logic           qtr_tick,
   input logic           defer_reply
);

   a_r1_reset_default: assert property (@(posedge clk)
      !rst_n |=> speed_code == ($past(strap_slow) ? 8'h04 : 8'h80));

   a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr_en && ctl_wr_data[0] && CAP[0]) |=> speed_code == 8'h01);

   a_r4_empty_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr_en && ((ctl_wr_data & CAP) == 8'h00)) |=> $stable(speed_code));

   a_r5_fifty_before_hundred: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr_en && ((ctl_wr_data & CAP) == 8'h88)) |=> speed_code == 8'h80);

   a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(speed_code) == 1);

   a_r6_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr_en |=> $stable(speed_code));

   a_r7_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_busy |=> $stable(div_tc));

   a_r8_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      qtr_tick |=> !qtr_tick);

   a_r9_defer_on: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_req && xfer_busy) |=> defer_reply);

   a_r9_defer_off: assert property (@(posedge clk) disable iff (!rst_n)
      !(aux_req && xfer_busy) |=> !defer_reply);

endmodule

bind ddc_rate_sel ddc_rate_sel_chk #(.CAP(CAP), .TCW(TCW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .strap_slow  (strap_slow),
   .ctl_wr_en   (ctl_wr_en),
   .ctl_wr_data (ctl_wr_data),
   .xfer_busy   (xfer_busy),
   .aux_req     (aux_req),
   .speed_code  (speed_code),
   .div_tc      (div_tc),
   .qtr_tick    (qtr_tick),
   .defer_reply (defer_reply)
);

// File: tb/ddc_rate_sel_tb.sv
module ddc_rate_sel_tb;

   localparam int unsigned REF = 4_000_000;
   localparam int          TW  = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strap_slow = 1'b0;
   logic          ctl_wr_en = 1'b0;
   logic [7:0]    ctl_wr_data = 8'h00;
   logic          xfer_busy = 1'b0;
   logic          aux_req = 1'b0;
   logic [7:0]    cap_map;
   logic [7:0]    speed_code;
   logic [TW-1:0] div_tc;
   logic          qtr_tick;
   logic          defer_reply;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   ddc_rate_sel #(.REF_HZ(REF)) u_dut (
      .clk(clk), .rst_n(rst_n), .strap_slow(strap_slow),
      .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
      .xfer_busy(xfer_busy), .aux_req(aux_req),
      .cap_map(cap_map), .speed_code(speed_code), .div_tc(div_tc),
      .qtr_tick(qtr_tick), .defer_reply(defer_reply)
   );

   // Speeds from the requirements, in bit/s, by code position.
   function automatic int rate_of(input int b);
      case (b)
         0: return 1000;
         1: return 3000;
         2: return 10000;
         3: return 100000;
         4: return 400000;
         5: return 1000000;
         7: return 50000;
         default: return 0;
      endcase
   endfunction

   function automatic int tc_of(input int b);
      return int'(REF) / (4 * rate_of(b)) - 1;
   endfunction

   function automatic bit supported(input int b);
      return (b == 0 || b == 1 || b == 2 || b == 3 || b == 7);
   endfunction

   // Behavioural reference model.
   int m_spd = 7, m_tc = 19, m_cnt = 0;
   bit m_tick = 0, m_defer = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_spd = strap_slow ? 2 : 7;
         m_tc = tc_of(m_spd);
         m_cnt = 0; m_tick = 0; m_defer = 0;
      end else begin
         if (m_cnt >= m_tc) begin m_cnt = 0; m_tick = 1; end
         else begin m_cnt = m_cnt + 1; m_tick = 0; end
         if (!xfer_busy) m_tc = tc_of(m_spd);
         m_defer = aux_req && xfer_busy;
         if (ctl_wr_en) begin
            int best;
            best = -1;
            for (int b = 0; b < 8; b++)
               if (ctl_wr_data[b] && supported(b) && (best < 0 || rate_of(b) < rate_of(best)))
                  best = b;
            if (best >= 0) m_spd = best;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(speed_code == 8'(1 << m_spd), "R6 speed_code vs model", speed_code, 1 << m_spd);
         check(int'(div_tc) == m_tc, "R7 div_tc vs model", div_tc, m_tc);
         check(qtr_tick == m_tick, "R8 qtr_tick vs model", qtr_tick, m_tick);
         check(defer_reply == m_defer, "R9 defer_reply vs model", defer_reply, m_defer);
      end
   end

   task automatic do_reset(input bit s);
      @(negedge clk);
      rst_n = 1'b0; strap_slow = s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      ctl_wr_en = 1'b1; ctl_wr_data = d;
      @(negedge clk);
      ctl_wr_en = 1'b0;
   endtask

   task automatic tick_gap(input int exp, input string req);
      int n;
      n = 0;
      while (!qtr_tick && n < 5000) begin @(negedge clk); n++; end
      n = 0;
      @(negedge clk); n = 1;
      while (!qtr_tick && n < 5000) begin @(negedge clk); n++; end
      check(n == exp, req, n, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset(1'b0);
      check(speed_code == 8'h80, "R1 default strap low", speed_code, 8'h80);
      check(div_tc == 10'd19, "R7 default tc strap low", div_tc, 19);
      check(cap_map == 8'h8F, "R2 capability map", cap_map, 8'h8F);
      check(!defer_reply && !qtr_tick, "R8 idle after reset", qtr_tick, 0);
      do_reset(1'b1);
      check(speed_code == 8'h04, "R1 default strap high", speed_code, 8'h04);
      check(div_tc == 10'd99, "R7 default tc strap high", div_tc, 99);
      repeat (3) @(negedge clk);

      wr(8'hFF);
      check(speed_code == 8'h01, "R3 all ones -> 1k", speed_code, 8'h01);
      wr(8'h0C);
      check(speed_code == 8'h04, "R3 0x0C -> 10k", speed_code, 8'h04);
      wr(8'h30);
      check(speed_code == 8'h04, "R4 unsupported-only mask", speed_code, 8'h04);
      wr(8'h40);
      check(speed_code == 8'h04, "R4 reserved-only mask", speed_code, 8'h04);
      wr(8'h88);
      check(speed_code == 8'h80, "R5 50k beats 100k", speed_code, 8'h80);
      wr(8'h08);
      check(speed_code == 8'h08, "R5 100k alone", speed_code, 8'h08);
      @(negedge clk);
      check(div_tc == 10'd9, "R7 tc for 100k", div_tc, 9);
      tick_gap(10, "R8 tick period at 100k");

      @(negedge clk); xfer_busy = 1'b1;
      wr(8'h01);
      repeat (4) @(negedge clk);
      check(speed_code == 8'h01, "R6 speed updated while busy", speed_code, 8'h01);
      check(div_tc == 10'd9, "R7 tc held while busy", div_tc, 9);
      aux_req = 1'b1;
      @(negedge clk); aux_req = 1'b0;
      check(defer_reply == 1'b1, "R9 defer while busy", defer_reply, 1);
      @(negedge clk);
      check(defer_reply == 1'b0, "R9 defer single cycle", defer_reply, 0);
      xfer_busy = 1'b0;
      @(negedge clk);
      check(div_tc == 10'd999, "R7 tc loaded once idle", div_tc, 999);
      aux_req = 1'b1;
      @(negedge clk); aux_req = 1'b0;
      check(defer_reply == 1'b0, "R9 no defer when idle", defer_reply, 0);
      tick_gap(1000, "R8 tick period at 1k");

      wr(8'h02);
      repeat (2) @(negedge clk);
      check(div_tc == 10'd332, "R7 tc for 3k", div_tc, 332);
      tick_gap(333, "R8 tick period at 3k");
      wr(8'h80);
      repeat (2) @(negedge clk);
      tick_gap(20, "R8 tick period at 50k");

      repeat (5) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule